// File: doc/BRIEF.md
# Calendar Real-Time Clock with Staged Commit and Alarm

This block keeps calendar time as seven fields: second, minute, hour, day of month, day of week, month and year. A one-cycle seconds pulse from outside advances the time. A second set of seven fields holds an alarm. Software reaches both sets through a small 16-bit register bus.

Writes to a time or alarm field do not change the running values directly. They land in staging registers and are marked as written. Writing a trigger register then starts a commit that lasts a fixed number of cycles, and a busy flag is visible for that whole time. When the commit ends, every marked field is copied into the live time and alarm registers in the same edge. Fields that were not written keep their live values, so live time fields go on counting.

The alarm compares the live time with the alarm fields on every seconds pulse. A mask register can leave chosen fields out of the compare. A match latches a status bit that drives the interrupt output, and reading the status register clears that bit. An optional one-shot mode disarms the alarm in the same edge that it fires. A separate sticky wake flag records that an alarm has fired.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the live time is year 0, month 1, day of month 1, day of week 0, 00:00:00. The busy bit reads 0, `irq` is low, and the enable register at 0x04 reads 0.
- R2: Live time fields read at byte offsets 0x0A + 2·i and committed alarm fields at 0x18 + 2·i. The field index i is 0 second, 1 minute, 2 hour, 3 day of month, 4 day of week, 5 month, 6 year. Each value is right-aligned in the 16-bit word.
- R3: A write to a time or alarm field register goes to staging only. The live value does not change until a commit completes.
- R4: A write to 0x3C with bit 0 set, made while idle, starts a commit. Bit 6 of 0x00 then reads 1 for exactly COMMIT_CYCLES cycles. All fields staged before the trigger reach the live registers together in the edge where busy clears.
- R5: A trigger made while busy is ignored. Field writes made while busy stay staged and are applied by the next trigger. A commit changes only the fields written since the previous trigger.
- R6: Each `sec_tick` advances the second. Second 59, minute 59 and hour 23 roll over to 0 and carry into the next field. The hour carry also advances day of week modulo 7, so 6 becomes 0.
- R7: Months run from 1 to 12. Months 4, 6, 9 and 11 have 30 days, and the other months except February have 31. February has 29 days when the year value is a multiple of 4, counting years from 1968, and 28 days otherwise. December rolls to January of the next year, and year 127 wraps to 0.
- R8: Bit 0 of 0x04 enables the alarm. With the alarm enabled, a tick whose new time matches the alarm sets bit 0 of 0x02. A match needs every field whose bit in 0x08 is 0 to be equal; bit i of 0x08 masks field i, so bit 4 masks day of week.
- R9: When bit 2 of 0x04 (one-shot) is set, a match clears bit 0 of 0x04 in the same edge that it sets the status bit. Without one-shot, the enable bit stays set.
- R10: A read of 0x02 returns the status and clears it in that edge. A match in the same cycle as the read wins, and the status stays set.
- R11: `irq` is high exactly while the alarm status bit is set.
- R12: An alarm match sets bit 4 of 0x2E. A write to 0x2E with bit 4 clear clears it, and a write with bit 4 set has no effect.
- R13: With the alarm disabled, or with an unmasked field that differs, a tick sets neither the status bit nor the wake flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset; bit 0 is ignored |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational; 0 when no read is made |
| sec_tick | input | 1 | One-cycle pulse once per second |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
The bench builds the block with COMMIT_CYCLES = 3 instead of the default 4. This keeps the busy window short, so a trigger made during the window and a field staged during it both fit inside a window that the bench counts cycle by cycle. A table of start times and expected next times covers every carry chain, including both kinds of February, 30-day months and the wrap of the year. Directed sequences then arm the alarm with and without masking and one-shot, and they check read-to-clear and the wake flag at the register interface.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 7;
    localparam int NFIELDS = 7;

    // register byte offsets
    localparam logic [ADDR_W-1:0] A_CTRL  = 7'h00;
    localparam logic [ADDR_W-1:0] A_ISTA  = 7'h02;
    localparam logic [ADDR_W-1:0] A_IEN   = 7'h04;
    localparam logic [ADDR_W-1:0] A_AMASK = 7'h08;
    localparam logic [ADDR_W-1:0] A_TIME0 = 7'h0A;
    localparam logic [ADDR_W-1:0] A_ALRM0 = 7'h18;
    localparam logic [ADDR_W-1:0] A_WAKE  = 7'h2E;
    localparam logic [ADDR_W-1:0] A_TRIG  = 7'h3C;

    localparam int BUSY_BIT = 6;
    localparam int WAKE_BIT = 4;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [2:0] dow;
        logic [4:0] dom;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_t;

    localparam cal_t CAL_RESET = '{year: 7'd0, mon: 4'd1, dow: 3'd0, dom: 5'd1,
                                   hour: 5'd0, min: 6'd0, sec: 6'd0};

    function automatic logic [DATA_W-1:0] get_field(cal_t c, logic [2:0] idx);
        case (idx)
            3'd0:    return DATA_W'(c.sec);
            3'd1:    return DATA_W'(c.min);
            3'd2:    return DATA_W'(c.hour);
            3'd3:    return DATA_W'(c.dom);
            3'd4:    return DATA_W'(c.dow);
            3'd5:    return DATA_W'(c.mon);
            3'd6:    return DATA_W'(c.year);
            default: return '0;
        endcase
    endfunction

    function automatic cal_t set_field(cal_t c, logic [2:0] idx, logic [DATA_W-1:0] d);
        cal_t r = c;
        case (idx)
            3'd0:    r.sec  = d[5:0];
            3'd1:    r.min  = d[5:0];
            3'd2:    r.hour = d[4:0];
            3'd3:    r.dom  = d[4:0];
            3'd4:    r.dow  = d[2:0];
            3'd5:    r.mon  = d[3:0];
            3'd6:    r.year = d[6:0];
            default: r = c;
        endcase
        return r;
    endfunction

    function automatic cal_t cal_merge(cal_t cur, cal_t nv, logic [NFIELDS-1:0] m);
        cal_t r = cur;
        for (int i = 0; i < NFIELDS; i++)
            if (m[i]) r = set_field(r, 3'(i), get_field(nv, 3'(i)));
        return r;
    endfunction

    function automatic logic [4:0] month_days(logic [3:0] mon, logic [6:0] year);
        case (mon)
            4'd2:                   return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                return 5'd31;
        endcase
    endfunction

    function automatic cal_t cal_advance(cal_t t);
        cal_t r = t;
        if (t.sec >= 6'd59) begin
            r.sec = '0;
            if (t.min >= 6'd59) begin
                r.min = '0;
                if (t.hour >= 5'd23) begin
                    r.hour = '0;
                    r.dow  = (t.dow >= 3'd6) ? 3'd0 : t.dow + 3'd1;
                    if (t.dom >= month_days(t.mon, t.year)) begin
                        r.dom = 5'd1;
                        if (t.mon >= 4'd12) begin
                            r.mon  = 4'd1;
                            r.year = t.year + 7'd1;
                        end else begin
                            r.mon = t.mon + 4'd1;
                        end
                    end else begin
                        r.dom = t.dom + 5'd1;
                    end
                end else begin
                    r.hour = t.hour + 5'd1;
                end
            end else begin
                r.min = t.min + 6'd1;
            end
        end else begin
            r.sec = t.sec + 6'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
    import rtc_cal_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [NFIELDS-1:0] load_mask,
    input  cal_t               load_val,
    output cal_t               time_q,
    output cal_t               time_next
);
    cal_t base;

    always_comb begin
        base      = tick ? cal_advance(time_q) : time_q;
        time_next = cal_merge(base, load_val, load_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) time_q <= CAL_RESET;
        else     time_q <= time_next;
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_cal_pkg::*;
(
    input  cal_t               now_t,
    input  cal_t               alarm_t,
    input  logic [NFIELDS-1:0] ignore,
    output logic               hit
);
    logic [NFIELDS-1:0] eq;

    for (genvar g = 0; g < NFIELDS; g++) begin : g_fld
        assign eq[g] = ignore[g] ||
                       (get_field(now_t, 3'(g)) == get_field(alarm_t, 3'(g)));
    end

    assign hit = &eq;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int COMMIT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sec_tick,
    output logic              irq
);
    localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);

    logic [ADDR_W-1:0] wa, t_off, a_off;
    logic              acc_wr, acc_rd, t_hit, a_hit;
    logic [2:0]        t_idx, a_idx;

    cal_t               sh_time, sh_alrm, pend_time, pend_alrm, alarm_q;
    cal_t               live_time, time_next;
    logic [NFIELDS-1:0] dirty_time, dirty_alrm, pend_mt, pend_ma, alarm_mask;
    logic [CNT_W-1:0]   cnt;
    logic               busy, apply, trig_ok, match, alarm_hit;
    logic               alm_en, one_shot, sta_alm, wake;

    // ---------------- address decode ----------------
    always_comb begin
        wa     = {bus_addr[ADDR_W-1:1], 1'b0};
        acc_wr = bus_sel && bus_wr;
        acc_rd = bus_sel && !bus_wr;
        t_off  = wa - A_TIME0;
        a_off  = wa - A_ALRM0;
        t_hit  = (wa >= A_TIME0) && (wa < A_TIME0 + ADDR_W'(2 * NFIELDS));
        a_hit  = (wa >= A_ALRM0) && (wa < A_ALRM0 + ADDR_W'(2 * NFIELDS));
        t_idx  = t_off[3:1];
        a_idx  = a_off[3:1];
    end

    assign busy    = (cnt != '0);
    assign apply   = (cnt == CNT_W'(1));
    assign trig_ok = acc_wr && (wa == A_TRIG) && bus_wdata[0] && !busy;

    // ---------------- staging and commit ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_time    <= CAL_RESET;
            sh_alrm    <= CAL_RESET;
            pend_time  <= CAL_RESET;
            pend_alrm  <= CAL_RESET;
            dirty_time <= '0;
            dirty_alrm <= '0;
            pend_mt    <= '0;
            pend_ma    <= '0;
            cnt        <= '0;
        end else begin
            if (trig_ok) begin
                pend_time  <= sh_time;
                pend_alrm  <= sh_alrm;
                pend_mt    <= dirty_time;
                pend_ma    <= dirty_alrm;
                dirty_time <= '0;
                dirty_alrm <= '0;
                cnt        <= CNT_W'(COMMIT_CYCLES);
            end else if (busy) begin
                cnt <= cnt - 1'b1;
            end
            if (acc_wr && t_hit) begin
                sh_time           <= set_field(sh_time, t_idx, bus_wdata);
                dirty_time[t_idx] <= 1'b1;
            end
            if (acc_wr && a_hit) begin
                sh_alrm           <= set_field(sh_alrm, a_idx, bus_wdata);
                dirty_alrm[a_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        alarm_q <= CAL_RESET;
        else if (apply) alarm_q <= cal_merge(alarm_q, pend_alrm, pend_ma);
    end

    rtc_cal_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .tick      (sec_tick),
        .load_mask (apply ? pend_mt : '0),
        .load_val  (pend_time),
        .time_q    (live_time),
        .time_next (time_next)
    );

    rtc_alarm_match u_match (
        .now_t   (time_next),
        .alarm_t (alarm_q),
        .ignore  (alarm_mask),
        .hit     (match)
    );

    assign alarm_hit = sec_tick && alm_en && match;

    // ---------------- interrupt control ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            alm_en     <= 1'b0;
            one_shot   <= 1'b0;
            alarm_mask <= '0;
            sta_alm    <= 1'b0;
            wake       <= 1'b0;
        end else begin
            if (acc_wr && wa == A_IEN) begin
                alm_en   <= bus_wdata[0];
                one_shot <= bus_wdata[2];
            end
            if (alarm_hit && one_shot) alm_en <= 1'b0;
            if (acc_wr && wa == A_AMASK) alarm_mask <= bus_wdata[NFIELDS-1:0];
            if (acc_rd && wa == A_ISTA) sta_alm <= 1'b0;
            if (alarm_hit) sta_alm <= 1'b1;
            if (acc_wr && wa == A_WAKE) wake <= wake && bus_wdata[WAKE_BIT];
            if (alarm_hit) wake <= 1'b1;
        end
    end

    assign irq = sta_alm;

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (acc_rd) begin
            case (wa)
                A_CTRL:  bus_rdata[BUSY_BIT] = busy;
                A_ISTA:  bus_rdata[0]        = sta_alm;
                A_IEN:   bus_rdata[2:0]      = {one_shot, 1'b0, alm_en};
                A_AMASK: bus_rdata           = DATA_W'(alarm_mask);
                A_WAKE:  bus_rdata[WAKE_BIT] = wake;
                default: begin
                    if (t_hit)      bus_rdata = get_field(live_time, t_idx);
                    else if (a_hit) bus_rdata = get_field(alarm_q, a_idx);
                end
            endcase
        end
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              sec_tick,
    input logic              irq,
    input logic              busy,
    input logic              apply,
    input logic              alm_en,
    input logic              one_shot,
    input logic              alarm_hit,
    input cal_t              live_time
);
    logic trig_idle, sta_read;
    assign trig_idle = bus_sel && bus_wr && ({bus_addr[ADDR_W-1:1], 1'b0} == A_TRIG)
                       && bus_wdata[0] && !busy;
    assign sta_read  = bus_sel && !bus_wr && ({bus_addr[ADDR_W-1:1], 1'b0} == A_ISTA);

    assert_trigger_starts_busy_R4: assert property (@(posedge clk) disable iff (rst)
        trig_idle |=> busy);

    assert_time_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !apply) |=> $stable(live_time));

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(alm_en));

    assert_oneshot_disarms_R9: assert property (@(posedge clk) disable iff (rst)
        (alarm_hit && one_shot) |=> (!alm_en && irq));

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (sta_read && !alarm_hit) |=> !irq);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sec_tick  (sec_tick),
    .irq       (irq),
    .busy      (busy),
    .apply     (apply),
    .alm_en    (alm_en),
    .one_shot  (one_shot),
    .alarm_hit (alarm_hit),
    .live_time (live_time)
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
    import rtc_cal_pkg::*;

    localparam int NCOMMIT = 3;
    localparam int NVEC    = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, sec_tick = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    rtc_calendar #(.COMMIT_CYCLES(NCOMMIT)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sec_tick(sec_tick), .irq(irq)
    );

    function automatic cal_t mk(int y, int mo, int dw, int d, int h, int mi, int s);
        cal_t c;
        c.year = 7'(y); c.mon = 4'(mo); c.dow = 3'(dw); c.dom = 5'(d);
        c.hour = 5'(h); c.min = 6'(mi); c.sec = 6'(s);
        return c;
    endfunction

    // start time -> time after one tick (R6, R7)
    localparam cal_t VIN [NVEC] = '{
        mk(0, 1, 0, 1, 0, 0, 0),      mk(3, 5, 2, 10, 4, 7, 59),
        mk(10, 6, 3, 15, 12, 59, 59), mk(0, 1, 6, 31, 23, 59, 59),
        mk(0, 2, 2, 28, 23, 59, 59),  mk(1, 2, 4, 28, 23, 59, 59),
        mk(4, 2, 1, 29, 23, 59, 59),  mk(20, 4, 5, 30, 23, 59, 59),
        mk(127, 12, 3, 31, 23, 59, 59), mk(50, 11, 6, 30, 23, 59, 59)};
    localparam cal_t VEXP [NVEC] = '{
        mk(0, 1, 0, 1, 0, 0, 1),      mk(3, 5, 2, 10, 4, 8, 0),
        mk(10, 6, 3, 15, 13, 0, 0),   mk(0, 2, 0, 1, 0, 0, 0),
        mk(0, 2, 3, 29, 0, 0, 0),     mk(1, 3, 5, 1, 0, 0, 0),
        mk(4, 3, 2, 1, 0, 0, 0),      mk(20, 5, 6, 1, 0, 0, 0),
        mk(0, 1, 4, 1, 0, 0, 0),      mk(50, 12, 0, 1, 0, 0, 0)};

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic wr(logic [6:0] a, logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        logic [15:0] s;
        n = 0;
        for (int k = 0; k < 20; k++) begin
            rd(A_CTRL, s);
            if (!s[6]) break;
            n++;
        end
    endtask

    task automatic commit();
        int n;
        wr(A_TRIG, 16'h0001);
        wait_idle(n);
    endtask

    task automatic stage_time(cal_t c);
        for (int i = 0; i < NFIELDS; i++)
            wr(A_TIME0 + 7'(2 * i), get_field(c, 3'(i)));
    endtask

    task automatic read_time(output cal_t c);
        logic [15:0] d;
        c = '0;
        rd(A_TIME0 + 7'd0,  d); c.sec  = d[5:0];
        rd(A_TIME0 + 7'd2,  d); c.min  = d[5:0];
        rd(A_TIME0 + 7'd4,  d); c.hour = d[4:0];
        rd(A_TIME0 + 7'd6,  d); c.dom  = d[4:0];
        rd(A_TIME0 + 7'd8,  d); c.dow  = d[2:0];
        rd(A_TIME0 + 7'd10, d); c.mon  = d[3:0];
        rd(A_TIME0 + 7'd12, d); c.year = d[6:0];
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        cal_t t;
        logic [15:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_time(t);
        check("R1 time", 64'(t), 64'(mk(0, 1, 0, 1, 0, 0, 0)));
        rd(A_CTRL, d); check("R1 busy", 64'(d), 64'h0);
        rd(A_IEN, d);  check("R1 enable", 64'(d), 64'h0);
        check("R1 irq", 64'(irq), 64'h0);

        // R3 staged write invisible; R4 busy length and commit
        wr(A_TIME0, 16'd30);
        rd(A_TIME0, d); check("R3 staged sec not live", 64'(d), 64'd0);
        wr(A_TRIG, 16'h0001);
        wait_idle(n);
        check("R4 busy cycles", 64'(n), 64'(NCOMMIT));
        rd(A_TIME0, d); check("R4 sec committed", 64'(d), 64'd30);

        // R5 trigger while busy ignored, write while busy kept for next trigger
        wr(A_TRIG, 16'h0001);
        wr(A_TIME0 + 7'd2, 16'd5);
        wr(A_TRIG, 16'h0001);
        wait_idle(n);
        check("R5 busy not restarted", 64'(n), 64'(NCOMMIT - 2));
        rd(A_TIME0 + 7'd2, d); check("R5 min held back", 64'(d), 64'd0);
        commit();
        rd(A_TIME0 + 7'd2, d); check("R5 min applied", 64'(d), 64'd5);
        rd(A_TIME0, d); check("R5 unwritten sec kept", 64'(d), 64'd30);

        // R6/R7 rollover table (also R2 field order)
        for (int v = 0; v < NVEC; v++) begin
            stage_time(VIN[v]);
            commit();
            tick();
            read_time(t);
            check($sformatf("R6 R7 R2 vector %0d", v), 64'(t), 64'(VEXP[v]));
        end

        // R8 alarm, dow masked and different, not one-shot
        stage_time(mk(30, 7, 2, 14, 10, 20, 30));
        wr(A_ALRM0 + 7'd0, 16'd32);  wr(A_ALRM0 + 7'd2, 16'd20);
        wr(A_ALRM0 + 7'd4, 16'd10);  wr(A_ALRM0 + 7'd6, 16'd14);
        wr(A_ALRM0 + 7'd8, 16'd5);   wr(A_ALRM0 + 7'd10, 16'd7);
        wr(A_ALRM0 + 7'd12, 16'd30);
        commit();
        rd(A_ALRM0, d);        check("R2 alarm sec", 64'(d), 64'd32);
        rd(A_ALRM0 + 7'd8, d); check("R2 alarm dow", 64'(d), 64'd5);
        wr(A_AMASK, 16'h0010);
        wr(A_IEN, 16'h0001);
        tick();
        check("R8 no early match", 64'(irq), 64'h0);
        tick();
        check("R8 R11 irq on match", 64'(irq), 64'h1);
        rd(A_IEN, d);  check("R9 enable kept without one-shot", 64'(d), 64'h1);
        rd(A_WAKE, d); check("R12 wake set", 64'(d), 64'h10);
        rd(A_ISTA, d); check("R10 status read", 64'(d), 64'h1);
        check("R10 R11 irq cleared by read", 64'(irq), 64'h0);
        rd(A_ISTA, d); check("R10 status cleared", 64'(d), 64'h0);
        wr(A_WAKE, 16'h0010);
        rd(A_WAKE, d); check("R12 write 1 no effect", 64'(d), 64'h10);
        wr(A_WAKE, 16'h0000);
        rd(A_WAKE, d); check("R12 write 0 clears", 64'(d), 64'h0);

        // R13 unmasked day of week differs
        wr(A_AMASK, 16'h0000);
        wr(A_TIME0, 16'd30); commit();
        tick(); tick();
        check("R13 dow mismatch irq", 64'(irq), 64'h0);
        rd(A_ISTA, d); check("R13 dow mismatch status", 64'(d), 64'h0);

        // R13 alarm disabled
        wr(A_AMASK, 16'h0010);
        wr(A_IEN, 16'h0000);
        wr(A_TIME0, 16'd30); commit();
        tick(); tick();
        check("R13 disabled irq", 64'(irq), 64'h0);
        rd(A_WAKE, d); check("R13 disabled wake", 64'(d), 64'h0);

        // R9 one-shot
        wr(A_IEN, 16'h0005);
        wr(A_TIME0, 16'd30); commit();
        tick(); tick();
        check("R9 one-shot irq", 64'(irq), 64'h1);
        rd(A_IEN, d); check("R9 one-shot disarms", 64'(d), 64'h4);

        done = 1'b1;
        summary();
    end
endmodule